// File: doc/BRIEF.md
# Interrupt Request Arbiter

This block sits beside an instruction-execution core and decides, at every instruction boundary, whether control must be diverted to an interrupt handler, and which source wins. It watches two request lines. The first is a non-maskable line that is not synchronous to the clock and reacts only to rising edges. The second is a maskable line that is level-sensitive and gated by the core's interrupt-enable flag.

The core pulses a boundary strobe at the end of each instruction, and also between element moves of a repeated block instruction. The block answers one cycle later with a take pulse, a select that names the winning source, and an 8-bit interrupt type. It also returns a request to clear the enable flag, which the core acts on. A trap input lets the core ask for that same clear when a software-raised interrupt reaches a boundary.

Top module: `irq_arbiter`

## Requirements
- R1: While reset is held, and on the first cycle after it, `take`, `sel_nm`, `vec_type` and `ien_clr` are 0 and no non-maskable request is pending.
- R2: A rising edge on `nmi_async` that stays high for at least 3 clock cycles is latched. The next boundary then produces `take`=1, `sel_nm`=1 and `vec_type`=2, even if the line has gone low by then.
- R3: The non-maskable line is edge-triggered. Holding it high after a serviced edge produces no further take, and its falling edge has no effect.
- R4: When a non-maskable request is pending and the maskable request qualifies at the same boundary, the non-maskable source wins. The maskable request is taken at a later boundary if it still qualifies then.
- R5: A rising edge that is detected after servicing has started re-arms the latch. This includes an edge detected in the very boundary cycle that consumes the previous request. It yields exactly one further non-maskable take.
- R6: The maskable request qualifies only if `mreq` was high during the clock cycle just before the boundary cycle. A level that is raised only in the boundary cycle is not honoured at that boundary. A level that is dropped in the boundary cycle is still honoured.
- R7: The maskable request is ignored at a boundary while `ien` is 0. The same level is taken again once `ien` is 1.
- R8: `ien_clr` is 1 in every cycle in which `take` is 1. It is also 1 in the cycle after a boundary that has `trap` high. A trap alone does not raise `take`.
- R9: `take` and `ien_clr` are 1 only in the cycle after a boundary cycle. When `take` is 0, `sel_nm` and `vec_type` are 0. A maskable take reports `sel_nm`=0 and `vec_type`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_async | input | 1 | Non-maskable request line, not synchronous to `clk`, rising-edge sensitive |
| mreq | input | 1 | Maskable request level |
| ien | input | 1 | Interrupt-enable flag from the core |
| bnd | input | 1 | Instruction or block-element boundary strobe |
| trap | input | 1 | Software interrupt at this boundary; asks for the enable clear only |
| take | output | 1 | One-cycle pulse: divert to an interrupt handler |
| sel_nm | output | 1 | 1 = non-maskable source, 0 = maskable |
| vec_type | output | 8 | Interrupt type (2 for non-maskable, 0 otherwise) |
| ien_clr | output | 1 | Request to clear the enable flag |

## Verification
Two collisions are provoked on purpose. In the first, a boundary arrives while a non-maskable edge is pending and the maskable level qualifies; the bench expects the non-maskable select, then expects the maskable take at the next boundary. In the second, a fresh non-maskable edge is placed so that the synchronizer reports it in the same cycle as the boundary that consumes the earlier edge. The bench times this by counting synchronizer stages from the negedge drive. It judges the result by expecting one extra non-maskable take at the following boundary, and none after that.

// File: rtl/irqa_pkg.sv
package irqa_pkg;

    localparam int unsigned TYPE_W = 8;
    localparam logic [TYPE_W-1:0] NM_TYPE = TYPE_W'(2);

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_NM   = 2'd1,
        SRC_MASK = 2'd2
    } src_e;

    typedef struct packed {
        logic              take;
        logic              nm;
        logic [TYPE_W-1:0] vtype;
        logic              clr;
    } grant_t;

    function automatic grant_t make_grant(src_e src, logic soft_clr);
        grant_t g;
        g.take  = (src != SRC_NONE);
        g.nm    = (src == SRC_NM);
        g.vtype = (src == SRC_NM) ? NM_TYPE : '0;
        g.clr   = (src != SRC_NONE) || soft_clr;
        return g;
    endfunction

endpackage

// File: rtl/irqa_sync.sv
module irqa_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/irqa_nmi_latch.sv
module irqa_nmi_latch (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    input  logic consume,
    output logic rise,
    output logic pending
);
    logic lvl_d;

    always_ff @(posedge clk) begin
        if (rst) lvl_d <= 1'b0;
        else     lvl_d <= lvl;
    end

    assign rise = lvl && !lvl_d;

    // A rise seen in the consuming cycle re-arms the latch.
    always_ff @(posedge clk) begin
        if (rst)          pending <= 1'b0;
        else if (consume) pending <= rise;
        else              pending <= pending || rise;
    end
endmodule

// File: rtl/irqa_prio.sv
module irqa_prio
    import irqa_pkg::*;
(
    input  logic   bnd,
    input  logic   nm_pend,
    input  logic   mreq_q,
    input  logic   ien,
    input  logic   trap,
    output grant_t grant,
    output logic   nm_consume
);
    src_e src;

    always_comb begin
        src = SRC_NONE;
        if (bnd) begin
            if (nm_pend)             src = SRC_NM;
            else if (mreq_q && ien)  src = SRC_MASK;
        end
    end

    assign grant      = make_grant(src, bnd && trap);
    assign nm_consume = (src == SRC_NM);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irqa_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              nmi_async,
    input  logic              mreq,
    input  logic              ien,
    input  logic              bnd,
    input  logic              trap,
    output logic              take,
    output logic              sel_nm,
    output logic [TYPE_W-1:0] vec_type,
    output logic              ien_clr
);
    logic   nmi_s;
    logic   nmi_rise;
    logic   nm_pend;
    logic   nm_consume;
    logic   mreq_q;
    grant_t grant_d;
    grant_t grant_q;

    irqa_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (nmi_async),
        .q   (nmi_s)
    );

    irqa_nmi_latch u_latch (
        .clk     (clk),
        .rst     (rst),
        .lvl     (nmi_s),
        .consume (nm_consume),
        .rise    (nmi_rise),
        .pending (nm_pend)
    );

    // Maskable level captured each edge: holds the previous cycle's value.
    always_ff @(posedge clk) begin
        if (rst) mreq_q <= 1'b0;
        else     mreq_q <= mreq;
    end

    irqa_prio u_prio (
        .bnd        (bnd),
        .nm_pend    (nm_pend),
        .mreq_q     (mreq_q),
        .ien        (ien),
        .trap       (trap),
        .grant      (grant_d),
        .nm_consume (nm_consume)
    );

    always_ff @(posedge clk) begin
        if (rst) grant_q <= '0;
        else     grant_q <= grant_d;
    end

    assign take     = grant_q.take;
    assign sel_nm   = grant_q.nm;
    assign vec_type = grant_q.vtype;
    assign ien_clr  = grant_q.clr;

    logic unused_rise;
    assign unused_rise = nmi_rise;
endmodule

// File: rtl/irqa_chk.sv
module irqa_chk
    import irqa_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ien,
    input logic              bnd,
    input logic              take,
    input logic              sel_nm,
    input logic [TYPE_W-1:0] vec_type,
    input logic              ien_clr
);
    p_take_after_bnd_r9: assert property (@(posedge clk) disable iff (rst)
        take |-> $past(bnd));

    p_clr_after_bnd_r8: assert property (@(posedge clk) disable iff (rst)
        ien_clr |-> $past(bnd));

    p_clr_with_take_r8: assert property (@(posedge clk) disable iff (rst)
        take |-> ien_clr);

    p_nm_type_r2: assert property (@(posedge clk) disable iff (rst)
        (take && sel_nm) |-> (vec_type == NM_TYPE));

    p_mask_needs_en_r7: assert property (@(posedge clk) disable iff (rst)
        (take && !sel_nm) |-> ($past(ien) && vec_type == '0));

    p_idle_zero_r9: assert property (@(posedge clk) disable iff (rst)
        !take |-> (!sel_nm && vec_type == '0));
endmodule

bind irq_arbiter irqa_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .ien      (ien),
    .bnd      (bnd),
    .take     (take),
    .sel_nm   (sel_nm),
    .vec_type (vec_type),
    .ien_clr  (ien_clr)
);

// File: tb/irq_arbiter_tb.sv
module irq_arbiter_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       nmi_async = 1'b0;
    logic       mreq = 1'b0;
    logic       ien = 1'b0;
    logic       bnd = 1'b0;
    logic       trap = 1'b0;
    logic       take, sel_nm, ien_clr;
    logic [7:0] vec_type;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    irq_arbiter u_dut (
        .clk(clk), .rst(rst), .nmi_async(nmi_async), .mreq(mreq),
        .ien(ien), .bnd(bnd), .trap(trap), .take(take),
        .sel_nm(sel_nm), .vec_type(vec_type), .ien_clr(ien_clr)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Outputs packed as {take, sel_nm, ien_clr, vec_type}
    function automatic logic [31:0] outs();
        return {21'd0, take, sel_nm, ien_clr, vec_type};
    endfunction

    function automatic logic [31:0] exp_o(logic t, logic n, logic c, logic [7:0] v);
        return {21'd0, t, n, c, v};
    endfunction

    // One boundary cycle; returns after the registered response is visible.
    task automatic boundary(input logic with_trap);
        @(negedge clk); bnd = 1'b1; trap = with_trap;
        @(negedge clk); bnd = 1'b0; trap = 1'b0;
    endtask

    task automatic nmi_pulse();
        @(negedge clk); nmi_async = 1'b1;
        repeat (3) @(negedge clk);
        nmi_async = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1", "outs in reset", outs(), exp_o(0, 0, 0, 8'd0));
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        check("R1", "outs after reset", outs(), exp_o(0, 0, 0, 8'd0));
        boundary(1'b0);
        check("R1", "no pending after reset", outs(), exp_o(0, 0, 0, 8'd0));
    endtask

    task automatic t_nmi_basic();
        nmi_pulse();
        boundary(1'b0);
        check("R2", "nm take after low line", outs(), exp_o(1, 1, 1, 8'd2));
        @(negedge clk);
        check("R9", "take is one pulse", outs(), exp_o(0, 0, 0, 8'd0));
    endtask

    task automatic t_nmi_level();
        @(negedge clk); nmi_async = 1'b1;
        repeat (4) @(negedge clk);
        boundary(1'b0);
        check("R3", "first take on held line", outs(), exp_o(1, 1, 1, 8'd2));
        boundary(1'b0);
        check("R3", "held level no retake", outs(), exp_o(0, 0, 0, 8'd0));
        @(negedge clk); nmi_async = 1'b0;
        repeat (4) @(negedge clk);
        boundary(1'b0);
        check("R3", "falling edge no effect", outs(), exp_o(0, 0, 0, 8'd0));
    endtask

    task automatic t_priority();
        ien = 1'b1; mreq = 1'b1;
        nmi_pulse();
        boundary(1'b0);
        check("R4", "nm wins collision", outs(), exp_o(1, 1, 1, 8'd2));
        boundary(1'b0);
        check("R4", "mask taken next", outs(), exp_o(1, 0, 1, 8'd0));
        mreq = 1'b0; ien = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_rearm_same_cycle();
        nmi_pulse();
        @(negedge clk); nmi_async = 1'b1;   // sync stage 1 captures next edge
        @(negedge clk);                     // stage 2 next edge -> rise in next cycle
        @(negedge clk); bnd = 1'b1;         // boundary coincides with rise
        @(negedge clk); bnd = 1'b0;
        check("R5", "take of old edge", outs(), exp_o(1, 1, 1, 8'd2));
        repeat (2) @(negedge clk);
        nmi_async = 1'b0;
        repeat (3) @(negedge clk);
        boundary(1'b0);
        check("R5", "re-armed take", outs(), exp_o(1, 1, 1, 8'd2));
        boundary(1'b0);
        check("R5", "only one extra take", outs(), exp_o(0, 0, 0, 8'd0));
    endtask

    task automatic t_mask_window();
        ien = 1'b1; mreq = 1'b0;
        repeat (2) @(negedge clk);
        @(negedge clk); mreq = 1'b1; bnd = 1'b1;
        @(negedge clk); bnd = 1'b0;
        check("R6", "raised in boundary cycle", outs(), exp_o(0, 0, 0, 8'd0));
        @(negedge clk); mreq = 1'b0; bnd = 1'b1;
        @(negedge clk); bnd = 1'b0;
        check("R6", "dropped in boundary cycle", outs(), exp_o(1, 0, 1, 8'd0));
        ien = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_mask_enable();
        mreq = 1'b1; ien = 1'b1;
        @(negedge clk);
        boundary(1'b0);
        check("R7", "enabled mask take", outs(), exp_o(1, 0, 1, 8'd0));
        ien = 1'b0;
        boundary(1'b0);
        check("R7", "masked while ien=0", outs(), exp_o(0, 0, 0, 8'd0));
        boundary(1'b0);
        check("R7", "still masked", outs(), exp_o(0, 0, 0, 8'd0));
        ien = 1'b1;
        boundary(1'b0);
        check("R7", "retaken after re-enable", outs(), exp_o(1, 0, 1, 8'd0));
        ien = 1'b0; mreq = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_trap();
        boundary(1'b1);
        check("R8", "trap clears enable only", outs(), exp_o(0, 0, 1, 8'd0));
        @(negedge clk); trap = 1'b1;
        @(negedge clk); trap = 1'b0;
        check("R8", "trap without boundary", outs(), exp_o(0, 0, 0, 8'd0));
    endtask

    task automatic t_no_boundary();
        ien = 1'b1; mreq = 1'b1;
        nmi_pulse();
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check("R9", "no take without boundary", outs(), exp_o(0, 0, 0, 8'd0));
        end
        mreq = 1'b0;
        @(negedge clk);
        boundary(1'b0);
        check("R9", "pending nm kept until boundary", outs(), exp_o(1, 1, 1, 8'd2));
        ien = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_nmi_basic();
        t_nmi_level();
        t_priority();
        t_rearm_same_cycle();
        t_mask_window();
        t_mask_enable();
        t_trap();
        t_no_boundary();
        repeat (3) @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual hung expected done");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule